// File: doc/BRIEF.md
# Clock Output Gating and Power Sequencer

This block sits between two external control pins and the two clock outputs of a programmable oscillator. It reads four configuration bits and the two pins, and from them works out several things. It picks the source of the reference output, either the undivided master clock or the prescaled clock. It decides whether each output should drive or float. It also decides whether the whole device should shut down. Every change of a drive enable is made only at a clock edge where that output's waveform was sampled low. As a result an output neither starts nor stops in the middle of a high phase.

Shutdown is sequenced. A request must hold through three rising edges of each output waveform, which is two full periods of the slower one, before it commits. Both outputs are then released at their next low level. Only after that is the oscillator-run signal dropped and register programming locked. After reset, and after every wake-up, both outputs stay dark for a fixed settling count of master cycles. All inputs are assumed to be already synchronous to the master clock. The waveform inputs are the output clock levels as seen once per master cycle.

Top module: `clkout_pwr_ctrl`

## Requirements
- R1: During reset and for the first SETTLE_CYC clocks after reset is released (default 8192), both drive enables are 0, `osc_run` is 1 and `prog_lock` is 0.
- R2: `ref_sel_div` (1 = prescaled clock) equals `cfg_sel0` when `cfg_en0` or `cfg_pd0` is 1. Otherwise it equals `cfg_sel0 & ctl0`, so with select set the pin chooses the divided clock when high.
- R3: The reference output is requested to drive unless `cfg_en0`=1, `cfg_pd0`=0 and `ctl0`=1. In that combination the pin acts as an active-low output enable.
- R4: With `cfg_pd1`=0, `ctl1` is an active-low enable for the main output. With `cfg_pd1`=1, the main output is always requested.
- R5: The shutdown request is `(ctl0 & cfg_pd0) | (ctl1 & cfg_pd1) | (ctl0 & ~cfg_en0 & ~cfg_sel0 & ~cfg_pd0)`.
- R6: A drive enable changes only on a clock edge where its waveform was sampled 0. The reference waveform is `wave_pre0` when `ref_sel_div`=1 and `wave_mclk` otherwise. The main waveform is `wave_main`.
- R7: A shutdown request commits only after both output waveforms have each shown three rising edges while the request held without a break. A single-cycle drop restarts the count.
- R8: After a commit, `osc_run` stays 1 until both drive enables are 0. It falls on the following edge.
- R9: `prog_lock` is 1 from commit until wake-up, and whenever `osc_run` is 0.
- R10: When the request goes away while powered down, `osc_run` returns to 1 on the next edge. Both drive enables then stay 0 for SETTLE_CYC clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl0 | input | 1 | First control pin (select / enable / power-down) |
| ctl1 | input | 1 | Second control pin (enable / power-down) |
| cfg_en0 | input | 1 | Reference pin acts as output enable |
| cfg_sel0 | input | 1 | Reference source select bit |
| cfg_pd0 | input | 1 | First pin acts as power-down |
| cfg_pd1 | input | 1 | Second pin acts as power-down |
| wave_mclk | input | 1 | Undivided master clock level |
| wave_pre0 | input | 1 | Prescaled reference clock level |
| wave_main | input | 1 | Divided main clock level |
| oe_ref | output | 1 | Reference output drive enable |
| oe_main | output | 1 | Main output drive enable |
| ref_sel_div | output | 1 | Reference source: 1 prescaled, 0 master |
| osc_run | output | 1 | Oscillator allowed to run |
| prog_lock | output | 1 | Register programming blocked |

## Verification
Two things can land on the same edge. The first is a shutdown commit. The second is a drive enable that is still waiting for its waveform to go low, or that is about to switch on. The bench holds each shutdown row of the decode table long enough to commit while both waveforms are still toggling, at two different main-clock periods. This makes the commit fall at different phases of each output. A reference model, stepped cycle by cycle, judges the result on every clock. A separate monitor confirms that no enable changed after a high sample and that the oscillator never stopped while an output was still driven.

// File: rtl/clkctl_pkg.sv
// Shared types for the clock output gating and power sequencer.
package clkctl_pkg;
    // Sequencer phases: settling after wake, running, releasing outputs, powered down
    typedef enum logic [1:0] {
        SEQ_SETTLE = 2'd0,
        SEQ_RUN    = 2'd1,
        SEQ_DRAIN  = 2'd2,
        SEQ_OFF    = 2'd3
    } seq_t;
endpackage

// File: rtl/clkctl_decode.sv
// Decodes the two control pins against the configuration bits.
// Produces the reference source select, a drive request per output and
// the device shutdown request. Purely combinational; assumes the pins are
// already synchronous to the master clock.
module clkctl_decode (
    input  logic ctl0,
    input  logic ctl1,
    input  logic en0,
    input  logic sel0,
    input  logic pd0,
    input  logic pd1,
    output logic ref_sel,
    output logic want0,
    output logic want1,
    output logic sd_req
);
    logic pin0_fixed;

    // Pin decode: source select, per-output requests, shutdown sources ORed
    always_comb begin
        pin0_fixed = en0 | pd0;
        ref_sel    = pin0_fixed ? sel0 : (sel0 & ctl0);
        want0      = ~(en0 & ~pd0 & ctl0);
        want1      = pd1 | ~ctl1;
        sd_req     = (ctl0 & pd0) | (ctl1 & pd1) | (ctl0 & ~en0 & ~sel0 & ~pd0);
    end
endmodule

// File: rtl/clkctl_persist.sv
// Shutdown persistence filter. While armed, counts rising edges of each
// output waveform (saturating at EDGES); full goes high once every
// waveform has reached EDGES. Dropping arm clears all counts.
// Assumes waveform inputs are sampled once per master clock.
module clkctl_persist #(
    parameter int EDGES = 3,
    parameter int NW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [NW-1:0] wave,
    output logic          full
);
    localparam int CW = $clog2(EDGES + 1);

    logic [NW-1:0] prev;
    logic [NW-1:0] done;

    // Previous waveform level for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= wave;
    end

    for (genvar g = 0; g < NW; g++) begin : g_cnt
        logic [CW-1:0] cnt;
        // Saturating rising-edge counter, cleared when not armed
        always_ff @(posedge clk) begin
            if (!rst_n || !arm)
                cnt <= '0;
            else if (wave[g] && !prev[g] && cnt != CW'(EDGES))
                cnt <= cnt + 1'b1;
        end
        assign done[g] = (cnt == CW'(EDGES));
    end

    assign full = &done;
endmodule

// File: rtl/clkctl_gate.sv
// Drive-enable register for one output. The enable may only change at an
// edge where the output waveform is sampled low, so the output neither
// starts nor ends inside a high phase. Assumes wave is the level the pad
// would drive, sampled on the master clock.
module clkctl_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic wave,
    input  logic target,
    output logic oe
);
    // Follow target only while the waveform is low
    always_ff @(posedge clk) begin
        if (!rst_n)    oe <= 1'b0;
        else if (!wave) oe <= target;
    end
endmodule

// File: rtl/clkout_pwr_ctrl.sv
// Top of the clock output gating and power sequencer. Ties together the
// pin decode, the shutdown persistence filter, two low-level drive gates
// and the sequencer (settle, run, drain, off). Assumes all inputs are
// synchronous to clk and that SETTLE_CYC >= 2.
module clkout_pwr_ctrl
    import clkctl_pkg::*;
#(
    parameter int SETTLE_CYC = 8192,
    parameter int PD_EDGES   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl0,
    input  logic ctl1,
    input  logic cfg_en0,
    input  logic cfg_sel0,
    input  logic cfg_pd0,
    input  logic cfg_pd1,
    input  logic wave_mclk,
    input  logic wave_pre0,
    input  logic wave_main,
    output logic oe_ref,
    output logic oe_main,
    output logic ref_sel_div,
    output logic osc_run,
    output logic prog_lock
);
    localparam int SCW = $clog2(SETTLE_CYC);
    localparam logic [SCW-1:0] SC_LAST = SCW'(SETTLE_CYC - 1);

    seq_t           state;
    logic [SCW-1:0] scnt;
    logic           want0, want1, sd_req;
    logic           arm, full, commit;
    logic [1:0]     waves;
    logic [1:0]     targets;
    logic [1:0]     oes;

    clkctl_decode u_dec (
        .ctl0    (ctl0),
        .ctl1    (ctl1),
        .en0     (cfg_en0),
        .sel0    (cfg_sel0),
        .pd0     (cfg_pd0),
        .pd1     (cfg_pd1),
        .ref_sel (ref_sel_div),
        .want0   (want0),
        .want1   (want1),
        .sd_req  (sd_req)
    );

    // Waveform each output pad would carry
    assign waves[0] = ref_sel_div ? wave_pre0 : wave_mclk;
    assign waves[1] = wave_main;

    assign arm    = sd_req && (state == SEQ_SETTLE || state == SEQ_RUN);
    assign commit = arm && full;

    clkctl_persist #(.EDGES(PD_EDGES), .NW(2)) u_pers (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .wave  (waves),
        .full  (full)
    );

    // Outputs are requested only in the run phase and never on a commit edge
    assign targets[0] = (state == SEQ_RUN) && want0 && !commit;
    assign targets[1] = (state == SEQ_RUN) && want1 && !commit;

    for (genvar g = 0; g < 2; g++) begin : g_gate
        clkctl_gate u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .wave   (waves[g]),
            .target (targets[g]),
            .oe     (oes[g])
        );
    end

    assign oe_ref  = oes[0];
    assign oe_main = oes[1];

    // Power sequencer: settle count, commit to drain, drain to off, wake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_SETTLE;
            scnt  <= '0;
        end else begin
            unique case (state)
                SEQ_SETTLE: begin
                    if (commit)               state <= SEQ_DRAIN;
                    else if (scnt == SC_LAST) state <= SEQ_RUN;
                    else                      scnt  <= scnt + 1'b1;
                end
                SEQ_RUN: begin
                    if (commit) state <= SEQ_DRAIN;
                end
                SEQ_DRAIN: begin
                    if (oes == 2'b00) state <= SEQ_OFF;
                end
                SEQ_OFF: begin
                    if (!sd_req) begin
                        state <= SEQ_SETTLE;
                        scnt  <= '0;
                    end
                end
                default: state <= SEQ_SETTLE;
            endcase
        end
    end

    assign osc_run   = (state != SEQ_OFF);
    assign prog_lock = (state == SEQ_DRAIN) || (state == SEQ_OFF);
endmodule

// File: rtl/clkout_pwr_ctrl_chk.sv
// Property checker for clkout_pwr_ctrl, attached by bind. Observes ports only.
module clkout_pwr_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic wave_mclk,
    input logic wave_pre0,
    input logic wave_main,
    input logic ref_sel_div,
    input logic oe_ref,
    input logic oe_main,
    input logic osc_run,
    input logic prog_lock
);
    logic w_ref;
    assign w_ref = ref_sel_div ? wave_pre0 : wave_mclk;

    a_r6_ref_low: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_ref != $past(oe_ref)) |-> !$past(w_ref));

    a_r6_main_low: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_main != $past(oe_main)) |-> !$past(wave_main));

    a_r8_stop_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_run) |-> (!oe_ref && !oe_main));

    a_r9_lock_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |-> prog_lock);

    a_r10_dark_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |-> (!oe_ref && !oe_main));

    a_r1_wake_dark: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_run) |=> (!oe_ref && !oe_main));
endmodule

bind clkout_pwr_ctrl clkout_pwr_ctrl_chk u_chk (.*);

// File: tb/clkout_pwr_ctrl_test.sv
module clkout_pwr_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 48;
    localparam int EDGES      = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl0 = 0, ctl1 = 0, en0 = 1, sel0 = 1, pd0 = 0, pd1 = 0;
    logic wm = 0, wp = 0, wn = 0;
    logic oe_ref, oe_main, ref_sel_div, osc_run, prog_lock;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    int np      = 10;
    int ticks   = 0;

    clkout_pwr_ctrl #(.SETTLE_CYC(SETTLE), .PD_EDGES(EDGES)) uut (
        .clk(clk), .rst_n(rst_n), .ctl0(ctl0), .ctl1(ctl1),
        .cfg_en0(en0), .cfg_sel0(sel0), .cfg_pd0(pd0), .cfg_pd1(pd1),
        .wave_mclk(wm), .wave_pre0(wp), .wave_main(wn),
        .oe_ref(oe_ref), .oe_main(oe_main), .ref_sel_div(ref_sel_div),
        .osc_run(osc_run), .prog_lock(prog_lock)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected values from the requirements
    function automatic logic f_sel();       // R2
        if (en0 || pd0) return sel0;
        return sel0 && ctl0;
    endfunction
    function automatic logic f_want0();     // R3
        return !(en0 && !pd0 && ctl0);
    endfunction
    function automatic logic f_want1();     // R4
        return pd1 ? 1'b1 : !ctl1;
    endfunction
    function automatic logic f_sd();        // R5
        if (pd0 && ctl0) return 1'b1;
        if (pd1 && ctl1) return 1'b1;
        if (!en0 && !sel0 && !pd0 && ctl0) return 1'b1;
        return 1'b0;
    endfunction

    // Behavioural reference model (phase 0 settle, 1 run, 2 drain, 3 off)
    int   m_ph = 0, m_sc = 0, m_r0 = 0, m_r1 = 0;
    logic m_p0 = 0, m_p1 = 0, m_oe0 = 0, m_oe1 = 0;
    logic lw0 = 0, lw1 = 0;
    always @(posedge clk) begin
        logic w0, w1, req, armed, fire, n0, n1;
        int   nph, nsc, nr0, nr1;
        if (!rst_n) begin
            m_ph = 0; m_sc = 0; m_r0 = 0; m_r1 = 0;
            m_p0 = 0; m_p1 = 0; m_oe0 = 0; m_oe1 = 0;
            lw0 = 0; lw1 = 0;
        end else begin
            w0 = f_sel() ? wp : wm;
            w1 = wn;
            req = f_sd();
            armed = req && (m_ph <= 1);
            fire = armed && m_r0 >= EDGES && m_r1 >= EDGES;
            n0 = w0 ? m_oe0 : (m_ph == 1 && f_want0() && !fire);
            n1 = w1 ? m_oe1 : (m_ph == 1 && f_want1() && !fire);
            nr0 = !armed ? 0 : ((w0 && !m_p0 && m_r0 < EDGES) ? m_r0 + 1 : m_r0);
            nr1 = !armed ? 0 : ((w1 && !m_p1 && m_r1 < EDGES) ? m_r1 + 1 : m_r1);
            nph = m_ph; nsc = m_sc;
            if (m_ph == 0) begin
                if (fire) nph = 2;
                else if (m_sc == SETTLE - 1) nph = 1;
                else nsc = m_sc + 1;
            end else if (m_ph == 1) begin
                if (fire) nph = 2;
            end else if (m_ph == 2) begin
                if (!m_oe0 && !m_oe1) nph = 3;
            end else if (!req) begin
                nph = 0; nsc = 0;
            end
            lw0 = w0; lw1 = w1;
            m_p0 = w0; m_p1 = w1; m_oe0 = n0; m_oe1 = n1;
            m_r0 = nr0; m_r1 = nr1; m_ph = nph; m_sc = nsc;
        end
    end

    task automatic cmp(input logic act, input logic exp, input string tag);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // Per-clock comparison against the model and the low-level monitor
    logic poe0 = 0, poe1 = 0;
    always @(negedge clk) begin
        cmp(ref_sel_div, f_sel(), "R2 ref_sel_div");
        cmp(oe_ref, m_oe0, "R3 oe_ref");
        cmp(oe_main, m_oe1, "R4 oe_main");
        cmp(osc_run, m_ph != 3, "R8 osc_run");
        cmp(prog_lock, m_ph >= 2, "R9 prog_lock");
        if (rst_n && oe_ref !== poe0)  cmp(lw0, 1'b0, "R6 ref changed on high");
        if (rst_n && oe_main !== poe1) cmp(lw1, 1'b0, "R6 main changed on high");
        poe0 = oe_ref; poe1 = oe_main;
    end

    // Waveform generator, driven after each rising edge
    always @(posedge clk) begin
        #2;
        cyc++;
        wm = cyc[0];
        wp = cyc[1];
        wn = (cyc % np) < (np / 2);
    end

    // Watchdog
    always @(posedge clk) begin
        ticks++;
        if (ticks > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #3;
        end
    endtask

    initial begin
        step(4);
        cmp(oe_ref, 1'b0, "R1 reset oe_ref");
        cmp(oe_main, 1'b0, "R1 reset oe_main");
        cmp(osc_run, 1'b1, "R1 reset osc_run");
        cmp(prog_lock, 1'b0, "R1 reset prog_lock");
        rst_n = 1'b1;
        step(SETTLE - 2);
        cmp(oe_ref | oe_main, 1'b0, "R1 dark while settling");
        step(24);
        cmp(oe_ref & oe_main, 1'b1, "R1 outputs up after settle");

        // Persistence: interrupted request must not commit
        pd1 = 1; ctl1 = 1;
        step(15);
        ctl1 = 0;
        step(1);
        ctl1 = 1;
        step(15);
        cmp(osc_run, 1'b1, "R7 interrupted request held off");
        cmp(prog_lock, 1'b0, "R7 no lock after interruption");
        step(70);
        cmp(osc_run, 1'b0, "R7 persistent request commits");
        ctl1 = 0;
        step(2);
        cmp(osc_run, 1'b1, "R10 wake restarts oscillator");
        cmp(oe_ref | oe_main, 1'b0, "R10 dark after wake");
        step(SETTLE + 24);

        // Walk every configuration and pin combination at two main periods
        for (int pass = 0; pass < 2; pass++) begin
            np = (pass == 0) ? 10 : 16;
            for (int c = 0; c < 16; c++) begin
                for (int p = 0; p < 4; p++) begin
                    {en0, sel0, pd0, pd1} = 4'(c);
                    {ctl0, ctl1} = 2'(p);
                    step(8);
                    cmp(ref_sel_div, f_sel(), "R2 decode row");
                    if (f_sd()) begin
                        step(100);
                        cmp(osc_run, 1'b0, "R5 shutdown row powers down");
                        cmp(prog_lock, 1'b1, "R9 locked when down");
                        ctl0 = 0; ctl1 = 0;
                        step(2);
                        cmp(osc_run, 1'b1, "R10 wake");
                        step(SETTLE + 24);
                    end else begin
                        step(24);
                        cmp(osc_run, 1'b1, "R5 no shutdown");
                        cmp(oe_ref, f_want0(), "R3 reference drive");
                        cmp(oe_main, f_want1(), "R4 main drive");
                    end
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule